// File: doc/BRIEF.md
# Speculative Inverted-Table Translation Unit

On a translation miss, this unit computes a hashed index into one inverted shadow table that is shared by the whole system. It then issues a read of that table and starts a verifying flat nested walk in the same cycle. The table data returns one cycle later. If the entry is valid and its stored tag equals the full key, the unit presents the stored system frame number at once as a speculative result. Dependent work can then go ahead before the walk finishes. The key is the VM identifier, the process identifier and the guest virtual page number.

The table is never updated when guest page table entries change, so an entry can be stale. The verifying walk is the only thing that catches a stale entry. When the walk reports back, the unit gives exactly one outcome pulse:
- a commit when the walked frame agrees with the speculation, or when no speculation was made;
- a squash when the walked frame disagrees with the speculation;
- a squash with fault status when the walk faults.

Two counters record the speculations issued and the misspeculations found.

The control is a four-state machine:
- `ST_IDLE` accepts a request, issues the table read and the walk start, and goes to `ST_LOOKUP`.
- `ST_LOOKUP` evaluates the returned entry. It goes to `ST_RESOLVE` if the walk has already finished, and otherwise to `ST_WAIT_WALK`.
- `ST_WAIT_WALK` stays put until the walk finishes, then goes to `ST_RESOLVE`.
- `ST_RESOLVE` emits the outcome and returns to `ST_IDLE`.

Top module: `spec_xlate_unit`

## Requirements
- R1: The table index is `vpn[IDX_W-1:0] ^ vmid ^ pid`, with each identifier zero-extended or truncated to IDX_W bits. `tbl_rd_en`, `walk_start` and this index all appear in the cycle a request is accepted.
- R2: `req_ready` is high only when no request is in flight. A request is accepted on `req_valid && req_ready`, and only one request is in flight at a time.
- R3: The table returns data in the cycle after the read. If the returned entry is valid and its tag equals `{vmid, pid, vpn}` of the request, `spec_valid` is high for that one cycle and `spec_sfn` carries the entry's frame.
- R4: If the returned entry is invalid, or its tag differs from the key, `spec_valid` stays low and the unit waits for the walk.
- R5: The unit pulses `done_valid` for exactly one cycle, in the cycle after the cycle in which `walk_done` is sampled high. `req_ready` returns high in the cycle after that pulse.
- R6: A speculation whose frame equals the walked frame, on a walk without fault, gives `done_squash=0` with `done_sfn` equal to the walked frame.
- R7: A speculation whose frame differs from the walked frame, on a walk without fault, gives `done_squash=1` with `done_fault=0`.
- R8: With no speculation and no walk fault, the outcome is a commit (`done_squash=0`) with `done_sfn` equal to the walked frame.
- R9: A faulting walk gives `done_squash=1` and `done_fault=1`, whether or not a speculation was issued.
- R10: `spec_count` increments once per `spec_valid` pulse. `misspec_count` increments once per R7 outcome. A fault never counts as a misspeculation.
- R11: After reset, `req_ready` is high, both counters are zero, and `spec_valid` and `done_valid` are low.
- R12: `walk_done` may arrive as early as the lookup cycle, which is the cycle after `walk_start`. The result is then still captured and resolved in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_vmid | input | VMID_W | VM identifier of the miss |
| req_pid | input | PID_W | Process identifier of the miss |
| req_vpn | input | VPN_W | Guest virtual page number |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_idx | output | IDX_W | Hashed table index |
| tbl_rd_entry_valid | input | 1 | Returned entry valid bit (one cycle after read) |
| tbl_rd_tag | input | KEY_W | Returned entry tag `{vmid,pid,vpn}` |
| tbl_rd_sfn | input | SFN_W | Returned entry system frame number |
| walk_start | output | 1 | Start pulse for the verifying walk |
| walk_key | output | KEY_W | Key `{vmid,pid,vpn}` handed to the walker |
| walk_done | input | 1 | Walk finished (one-cycle pulse) |
| walk_fault | input | 1 | Walk hit a fault |
| walk_sfn | input | SFN_W | Walked system frame number |
| spec_valid | output | 1 | Speculative translation available |
| spec_sfn | output | SFN_W | Speculative system frame number |
| done_valid | output | 1 | Outcome pulse |
| done_squash | output | 1 | Outcome requires squash and replay |
| done_fault | output | 1 | Squash caused by walk fault |
| done_sfn | output | SFN_W | Verified system frame number |
| spec_count | output | CNT_W | Speculations issued |
| misspec_count | output | CNT_W | Misspeculations detected |

## Verification
The bench drives misses against table entries of several kinds:
- An entry that hits and agrees with the walk separates a confirm from a squash.
- An entry that hits but holds a stale frame separates a confirm from a squash on the other side.
- Entries that are invalid, or whose tag differs in one bit, show that no speculation is made without a full key match, and that the walked frame is still delivered.

Faulting walks, both after a speculation and without one, show that fault status dominates and stays out of the misspeculation count. The walk latency is varied down to an answer in the lookup cycle, and a process identifier with high bits set shows that the index folding truncates them.

// File: rtl/sit_pkg.sv
package sit_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_LOOKUP    = 2'd1,
        ST_WAIT_WALK = 2'd2,
        ST_RESOLVE   = 2'd3
    } sit_state_e;
endpackage

// File: rtl/sit_key_hash.sv
// Folds VM id and process id into the low VPN bits to form the table index,
// and forms the full lookup key used as the tag.
module sit_key_hash #(
    parameter int VMID_W = 4,
    parameter int PID_W  = 8,
    parameter int VPN_W  = 20,
    parameter int IDX_W  = 6,
    localparam int KEY_W = VMID_W + PID_W + VPN_W
) (
    input  logic [VMID_W-1:0] vmid,
    input  logic [PID_W-1:0]  pid,
    input  logic [VPN_W-1:0]  vpn,
    output logic [IDX_W-1:0]  idx,
    output logic [KEY_W-1:0]  key
);
    logic [IDX_W-1:0] vm_fold;
    logic [IDX_W-1:0] pid_fold;

    for (genvar i = 0; i < IDX_W; i++) begin : g_fold
        if (i < VMID_W) begin : g_vm
            assign vm_fold[i] = vmid[i];
        end else begin : g_vm_zero
            assign vm_fold[i] = 1'b0;
        end
        if (i < PID_W) begin : g_pid
            assign pid_fold[i] = pid[i];
        end else begin : g_pid_zero
            assign pid_fold[i] = 1'b0;
        end
    end

    assign idx = vpn[IDX_W-1:0] ^ vm_fold ^ pid_fold;
    assign key = {vmid, pid, vpn};
endmodule

// File: rtl/sit_event_counter.sv
module sit_event_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/spec_xlate_unit.sv
module spec_xlate_unit
    import sit_pkg::*;
#(
    parameter int VMID_W = 4,
    parameter int PID_W  = 8,
    parameter int VPN_W  = 20,
    parameter int IDX_W  = 6,
    parameter int SFN_W  = 16,
    parameter int CNT_W  = 16,
    localparam int KEY_W = VMID_W + PID_W + VPN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VMID_W-1:0] req_vmid,
    input  logic [PID_W-1:0]  req_pid,
    input  logic [VPN_W-1:0]  req_vpn,
    output logic              tbl_rd_en,
    output logic [IDX_W-1:0]  tbl_rd_idx,
    input  logic              tbl_rd_entry_valid,
    input  logic [KEY_W-1:0]  tbl_rd_tag,
    input  logic [SFN_W-1:0]  tbl_rd_sfn,
    output logic              walk_start,
    output logic [KEY_W-1:0]  walk_key,
    input  logic              walk_done,
    input  logic              walk_fault,
    input  logic [SFN_W-1:0]  walk_sfn,
    output logic              spec_valid,
    output logic [SFN_W-1:0]  spec_sfn,
    output logic              done_valid,
    output logic              done_squash,
    output logic              done_fault,
    output logic [SFN_W-1:0]  done_sfn,
    output logic [CNT_W-1:0]  spec_count,
    output logic [CNT_W-1:0]  misspec_count
);
    sit_state_e state_q, state_d;

    logic [KEY_W-1:0] key_now;
    logic [KEY_W-1:0] key_q;
    logic             hit;
    logic             spec_hit_q;
    logic [SFN_W-1:0] spec_sfn_q;
    logic             wfault_q;
    logic [SFN_W-1:0] wsfn_q;
    logic             accept;
    logic             walk_seen;
    logic             frame_differs;
    logic             misspec_inc;

    sit_key_hash #(
        .VMID_W(VMID_W), .PID_W(PID_W), .VPN_W(VPN_W), .IDX_W(IDX_W)
    ) u_hash (
        .vmid (req_vmid),
        .pid  (req_pid),
        .vpn  (req_vpn),
        .idx  (tbl_rd_idx),
        .key  (key_now)
    );

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign hit       = (state_q == ST_LOOKUP) && tbl_rd_entry_valid && (tbl_rd_tag == key_q);
    assign walk_seen = walk_done && ((state_q == ST_LOOKUP) || (state_q == ST_WAIT_WALK));
    assign frame_differs = spec_hit_q && (spec_sfn_q != wsfn_q);
    assign misspec_inc   = (state_q == ST_RESOLVE) && frame_differs && !wfault_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:    state_d = walk_done ? ST_RESOLVE : ST_WAIT_WALK;
            ST_WAIT_WALK: if (walk_done) state_d = ST_RESOLVE;
            ST_RESOLVE:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured request and results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q      <= '0;
            spec_hit_q <= 1'b0;
            spec_sfn_q <= '0;
            wfault_q   <= 1'b0;
            wsfn_q     <= '0;
        end else begin
            if (accept) begin
                key_q      <= key_now;
                spec_hit_q <= 1'b0;
            end
            if (state_q == ST_LOOKUP) begin
                spec_hit_q <= hit;
                spec_sfn_q <= tbl_rd_sfn;
            end
            if (walk_seen) begin
                wfault_q <= walk_fault;
                wsfn_q   <= walk_sfn;
            end
        end
    end

    // Outputs
    always_comb begin
        req_ready   = 1'b0;
        tbl_rd_en   = 1'b0;
        walk_start  = 1'b0;
        walk_key    = key_now;
        spec_valid  = 1'b0;
        spec_sfn    = '0;
        done_valid  = 1'b0;
        done_squash = 1'b0;
        done_fault  = 1'b0;
        done_sfn    = '0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready  = 1'b1;
                tbl_rd_en  = req_valid;
                walk_start = req_valid;
            end
            ST_LOOKUP: begin
                spec_valid = hit;
                spec_sfn   = hit ? tbl_rd_sfn : '0;
            end
            ST_WAIT_WALK: begin
            end
            ST_RESOLVE: begin
                done_valid  = 1'b1;
                done_squash = wfault_q || frame_differs;
                done_fault  = wfault_q;
                done_sfn    = wsfn_q;
            end
            default: begin
            end
        endcase
    end

    sit_event_counter #(.W(CNT_W)) u_spec_cnt (
        .clk(clk), .rst_n(rst_n), .inc(hit), .count(spec_count)
    );
    sit_event_counter #(.W(CNT_W)) u_miss_cnt (
        .clk(clk), .rst_n(rst_n), .inc(misspec_inc), .count(misspec_count)
    );

    // Assertions
    p_single_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
        walk_start |=> !req_ready);
    p_spec_after_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        spec_valid |-> $past(walk_start));
    p_outcome_after_walk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> $past(walk_done));
    p_ready_after_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> (req_ready && !done_valid));
    p_fault_is_squash_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_fault |-> (done_valid && done_squash));
    p_spec_count_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        spec_valid |=> (spec_count == $past(spec_count) + CNT_W'(1)));
    p_fault_not_misspec_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_fault |=> $stable(misspec_count));
endmodule

// File: tb/spec_xlate_unit_tb_top.sv
module spec_xlate_unit_tb_top;
    localparam int VMID_W = 4;
    localparam int PID_W  = 8;
    localparam int VPN_W  = 20;
    localparam int IDX_W  = 6;
    localparam int SFN_W  = 16;
    localparam int CNT_W  = 16;
    localparam int KEY_W  = VMID_W + PID_W + VPN_W;
    localparam int DEPTH  = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VMID_W-1:0] req_vmid = '0;
    logic [PID_W-1:0]  req_pid = '0;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic              tbl_rd_en;
    logic [IDX_W-1:0]  tbl_rd_idx;
    logic              tbl_rd_entry_valid;
    logic [KEY_W-1:0]  tbl_rd_tag;
    logic [SFN_W-1:0]  tbl_rd_sfn;
    logic              walk_start;
    logic [KEY_W-1:0]  walk_key;
    logic              walk_done = 1'b0;
    logic              walk_fault = 1'b0;
    logic [SFN_W-1:0]  walk_sfn = '0;
    logic              spec_valid;
    logic [SFN_W-1:0]  spec_sfn;
    logic              done_valid;
    logic              done_squash;
    logic              done_fault;
    logic [SFN_W-1:0]  done_sfn;
    logic [CNT_W-1:0]  spec_count;
    logic [CNT_W-1:0]  misspec_count;

    spec_xlate_unit dut_i (.*);

    // Table model: registered read, one cycle latency
    logic             mem_v   [DEPTH];
    logic [KEY_W-1:0] mem_tag [DEPTH];
    logic [SFN_W-1:0] mem_sfn [DEPTH];
    always @(posedge clk) begin
        if (tbl_rd_en) begin
            tbl_rd_entry_valid <= mem_v[tbl_rd_idx];
            tbl_rd_tag         <= mem_tag[tbl_rd_idx];
            tbl_rd_sfn         <= mem_sfn[tbl_rd_idx];
        end
    end

    int checks = 0;
    int errors = 0;
    int exp_spec_cnt = 0;
    int exp_miss_cnt = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [IDX_W-1:0] exp_idx(input logic [VMID_W-1:0] v,
                                                 input logic [PID_W-1:0] p,
                                                 input logic [VPN_W-1:0] n);
        return n[IDX_W-1:0] ^ {2'b00, v} ^ p[IDX_W-1:0];
    endfunction

    // One miss: place an entry, issue the request, answer the walk after
    // 'delay' cycles (0 = in the lookup cycle), check every stage.
    task automatic run_miss(input string req, input logic [VMID_W-1:0] v,
                            input logic [PID_W-1:0] p, input logic [VPN_W-1:0] n,
                            input bit ent_valid, input bit tag_ok,
                            input logic [SFN_W-1:0] ent_sfn, input int delay,
                            input bit wf, input logic [SFN_W-1:0] wsfn);
        logic [IDX_W-1:0] ix;
        logic [KEY_W-1:0] k;
        bit exp_spec, exp_sq;
        ix = exp_idx(v, p, n);
        k  = {v, p, n};
        mem_v[ix]   = ent_valid;
        mem_tag[ix] = tag_ok ? k : (k ^ KEY_W'(1));
        mem_sfn[ix] = ent_sfn;
        exp_spec = ent_valid && tag_ok;
        exp_sq   = wf || (exp_spec && (ent_sfn != wsfn));

        @(negedge clk);
        req_valid = 1'b1; req_vmid = v; req_pid = p; req_vpn = n;
        #1;
        check(req_ready == 1'b1, "R2", {req, " ready when idle"}, 64'(req_ready), 64'd1);
        check(tbl_rd_en && walk_start, "R1", {req, " read+walk start"},
              64'({tbl_rd_en, walk_start}), 64'd3);
        check(tbl_rd_idx == ix, "R1", {req, " index"}, 64'(tbl_rd_idx), 64'(ix));
        check(walk_key == k, "R1", {req, " walk key"}, 64'(walk_key), 64'(k));

        @(negedge clk);
        req_valid = 1'b0;
        if (delay == 0) begin
            walk_done = 1'b1; walk_fault = wf; walk_sfn = wsfn;
        end
        #1;
        check(req_ready == 1'b0, "R2", {req, " busy in lookup"}, 64'(req_ready), 64'd0);
        check(spec_valid == exp_spec, exp_spec ? "R3" : "R4", {req, " spec_valid"},
              64'(spec_valid), 64'(exp_spec));
        if (exp_spec) begin
            check(spec_sfn == ent_sfn, "R3", {req, " spec_sfn"}, 64'(spec_sfn), 64'(ent_sfn));
            exp_spec_cnt++;
        end

        for (int d = 1; d <= delay; d++) begin
            @(negedge clk);
            if (d == delay) begin
                walk_done = 1'b1; walk_fault = wf; walk_sfn = wsfn;
            end
            #1;
            check(done_valid == 1'b0 && spec_valid == 1'b0, "R5", {req, " quiet while waiting"},
                  64'({done_valid, spec_valid}), 64'd0);
        end

        @(negedge clk);
        walk_done = 1'b0; walk_fault = 1'b0; walk_sfn = '0;
        #1;
        check(done_valid == 1'b1, (delay == 0) ? "R12" : "R5", {req, " outcome pulse"},
              64'(done_valid), 64'd1);
        check(done_squash == exp_sq, req, {req, " squash"}, 64'(done_squash), 64'(exp_sq));
        check(done_fault == wf, wf ? "R9" : req, {req, " fault"}, 64'(done_fault), 64'(wf));
        if (!wf)
            check(done_sfn == wsfn, req, {req, " verified frame"}, 64'(done_sfn), 64'(wsfn));
        if (!wf && exp_spec && (ent_sfn != wsfn)) exp_miss_cnt++;

        @(negedge clk);
        #1;
        check(req_ready == 1'b1 && done_valid == 1'b0, "R5", {req, " back to idle"},
              64'({req_ready, done_valid}), 64'd2);
        check(spec_count == CNT_W'(exp_spec_cnt), "R10", {req, " spec_count"},
              64'(spec_count), 64'(exp_spec_cnt));
        check(misspec_count == CNT_W'(exp_miss_cnt), "R10", {req, " misspec_count"},
              64'(misspec_count), 64'(exp_miss_cnt));
    endtask

    task automatic test_reset_r11();
        @(negedge clk);
        #1;
        check(req_ready == 1'b1, "R11", "ready after reset", 64'(req_ready), 64'd1);
        check(spec_count == '0 && misspec_count == '0, "R11", "counters after reset",
              64'({spec_count, misspec_count}), 64'd0);
        check(spec_valid == 1'b0 && done_valid == 1'b0, "R11", "outputs after reset",
              64'({spec_valid, done_valid}), 64'd0);
    endtask

    task automatic test_hit_confirm_r6();
        run_miss("R6", 4'h3, 8'h11, 20'h0ABCD, 1'b1, 1'b1, 16'h1234, 2, 1'b0, 16'h1234);
    endtask
    task automatic test_stale_squash_r7();
        run_miss("R7", 4'h5, 8'h22, 20'h12345, 1'b1, 1'b1, 16'h0F0F, 1, 1'b0, 16'h0F0E);
    endtask
    task automatic test_tag_miss_r8();
        run_miss("R8", 4'h1, 8'h07, 20'h00040, 1'b1, 1'b0, 16'hAAAA, 3, 1'b0, 16'h5555);
    endtask
    task automatic test_invalid_entry_r4();
        run_miss("R4", 4'h9, 8'h30, 20'h77777, 1'b0, 1'b1, 16'hBEEF, 1, 1'b0, 16'hBEEF);
    endtask
    task automatic test_fault_after_spec_r9();
        run_miss("R9", 4'h2, 8'h44, 20'h00100, 1'b1, 1'b1, 16'h2222, 2, 1'b1, 16'h3333);
    endtask
    task automatic test_fault_no_spec_r9();
        run_miss("R9", 4'h6, 8'h15, 20'h0F00F, 1'b0, 1'b0, 16'h0000, 1, 1'b1, 16'h0001);
    endtask
    task automatic test_early_walk_r12();
        run_miss("R7", 4'hA, 8'h3C, 20'h55555, 1'b1, 1'b1, 16'h7777, 0, 1'b0, 16'h7778);
    endtask
    task automatic test_hash_trunc_r1();
        run_miss("R6", 4'hF, 8'hC5, 20'hFFFC0, 1'b1, 1'b1, 16'h4321, 1, 1'b0, 16'h4321);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_v[i] = 1'b0; mem_tag[i] = '0; mem_sfn[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset_r11();
        test_hit_confirm_r6();
        test_stale_squash_r7();
        test_tag_miss_r8();
        test_invalid_entry_r4();
        test_fault_after_spec_r9();
        test_fault_no_spec_r9();
        test_early_walk_r12();
        test_hash_trunc_r1();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule